// File: doc/BRIEF.md
# Indirect Dual-RAM Access Bridge

This block lets a bus host reach two external synchronous RAMs through a small set of registers, one access at a time. The first RAM is a table memory with 128-bit entries and 8-bit addressing. The second is a byte-wide buffer memory with 14-bit addressing. The host first loads holding registers with data and, for table writes, with a per-bit enable mask. It then writes one command word that names the memory, the direction and the address. The bridge carries out that one access and raises a completion flag, which the host polls.

A table write merges data into the stored entry under the mask. The bridge reads the old entry and writes back `(old & ~mask) | (data & mask)`. The flag rises only after the write-back. A read puts the fetched entry, or the fetched byte, into the data holding registers. A command that arrives while an access is still running is dropped, and a sticky error bit is set.

Top module: `indirect_ram_bridge`

## Requirements
- R1: Each accepted command causes exactly one RAM access: one read cycle for a read, one write cycle for a buffer write, and one read cycle followed by one write cycle for a table write. Presenting the command offset on `hostAddr` without a write, or leaving the bridge idle, causes no RAM access.
- R2: Command word fields: bit 31 = 1 means write and 0 means read; bit 30 = 0 selects the table RAM and 1 selects the buffer RAM. The table address is bits [7:0] and the buffer address is bits [13:0]. Reading the command offset returns the last accepted command.
- R3: A table write stores `(old & ~WE) | (DAT & WE)`. DATk and WEk (k = 0..3) cover entry bits [32k+31:32k].
- R4: A table read loads DATk with entry bits [32k+31:32k], for all four words.
- R5: A buffer write stores DAT0[7:0] at the buffer address. DAT1..DAT3 and all WE registers have no effect, and the table RAM is not touched.
- R6: A buffer read sets DAT0 to the fetched byte zero-extended to 32 bits. DAT1..DAT3 keep their values.
- R7: The done flag (status bit 0) is first seen set 1 clock after the command write edge for a buffer write, 2 clocks after it for any read, and 3 clocks after it for a table write.
- R8: Accepting a command clears the done flag. A host write to status with bit 0 = 0 also clears it. If a completion and such a clear fall in the same cycle, the flag ends up set.
- R9: A command written while an access is in progress is ignored: the command register is unchanged and no extra RAM access occurs. It sets the sticky error flag (status bit 1), which stays set until the host writes status with bit 1 = 0.
- R10: After reset, all registers read zero and no RAM access is issued.
- R11: Register offsets: 0 command, 1 status, 2..5 DAT0..DAT3, 6..9 WE0..WE3. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 4 | Host register offset |
| hostWData | input | 32 | Host write data |
| hostRData | output | 32 | Host read data for `hostAddr` (combinational) |
| tblEn | output | 1 | Table RAM cycle enable |
| tblWe | output | 1 | Table RAM write enable |
| tblAddr | output | 8 | Table RAM address |
| tblWData | output | 128 | Table RAM write data |
| tblRData | input | 128 | Table RAM read data, valid one clock after the address |
| bufEn | output | 1 | Buffer RAM cycle enable |
| bufWe | output | 1 | Buffer RAM write enable |
| bufAddr | output | 14 | Buffer RAM address |
| bufWData | output | 8 | Buffer RAM write data |
| bufRData | input | 8 | Buffer RAM read data, valid one clock after the address |

## Verification
Two collisions can land in one cycle. In the first, the host clears the status register in the very cycle that a read completes. The bench issues a buffer read and times a status write of zero to hit the edge that sets the done flag; it then expects the flag set, and expects a later clear to take effect. In the second, a new command arrives one clock after the first, while the bridge is busy. The bench judges this at the ports: the command readback still shows the first command, the buffer RAM sees no write, the error bit is set, and it clears when written with 0.

// File: rtl/rambridge_pkg.sv
package rambridge_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_CAP  = 2'd2,
    S_WB   = 2'd3
  } bridgeState_t;

  typedef struct packed {
    logic accept;
    logic ramRd;
    logic ramWr;
    logic capRead;
    logic capOld;
    logic setDone;
    logic setErr;
    logic tgtBuf;
  } ctlStrobe_t;

  localparam int REG_CMD  = 0;
  localparam int REG_STAT = 1;
  localparam int REG_DAT0 = 2;

endpackage

// File: rtl/rambridge_ctrl.sv
module rambridge_ctrl
  import rambridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrite,
  input  logic       cmdWnr,
  input  logic       cmdTgt,
  output ctlStrobe_t stb,
  output logic       busy
);

  bridgeState_t state, stateNext;
  logic wnrQ, tgtQ;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (cmdWrite) stateNext = (cmdWnr && cmdTgt) ? S_WB : S_RD;
      S_RD:    stateNext = S_CAP;
      S_CAP:   stateNext = wnrQ ? S_WB : S_IDLE;
      S_WB:    stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      wnrQ  <= 1'b0;
      tgtQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && cmdWrite) begin
        wnrQ <= cmdWnr;
        tgtQ <= cmdTgt;
      end
    end
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    stb.accept  = !busy && cmdWrite;
    stb.ramRd   = (state == S_RD);
    stb.ramWr   = (state == S_WB);
    stb.capRead = (state == S_CAP) && !wnrQ;
    stb.capOld  = (state == S_CAP) && wnrQ;
    stb.setDone = ((state == S_CAP) && !wnrQ) || (state == S_WB);
    stb.setErr  = busy && cmdWrite;
    stb.tgtBuf  = tgtQ;
  end

  // R1: with no command the sequencer stays idle
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !cmdWrite) |=> (state == S_IDLE));

  // R3: a masked table write always goes on to the write-back cycle
  p_rmw_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CAP && wnrQ) |=> (state == S_WB));

  // R7: the write-back cycle is the last one
  p_wb_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WB) |=> (state == S_IDLE));

endmodule

// File: rtl/rambridge_dp.sv
module rambridge_dp
  import rambridge_pkg::*;
#(
  parameter int HDW     = 32,
  parameter int TDW     = 128,
  parameter int TAW     = 8,
  parameter int BDW     = 8,
  parameter int BAW     = 14,
  parameter int RAW     = 4,
  parameter int WNR_BIT = 31,
  parameter int TGT_BIT = 30
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctlStrobe_t     stb,
  input  logic           busy,
  input  logic           hostWrEn,
  input  logic [RAW-1:0] hostAddr,
  input  logic [HDW-1:0] hostWData,
  output logic [HDW-1:0] hostRData,
  output logic           cmdWrite,
  output logic           cmdWnr,
  output logic           cmdTgt,
  output logic           tblEn,
  output logic           tblWe,
  output logic [TAW-1:0] tblAddr,
  output logic [TDW-1:0] tblWData,
  input  logic [TDW-1:0] tblRData,
  output logic           bufEn,
  output logic           bufWe,
  output logic [BAW-1:0] bufAddr,
  output logic [BDW-1:0] bufWData,
  input  logic [BDW-1:0] bufRData
);

  localparam int WORDS   = TDW / HDW;
  localparam int REG_WE0 = REG_DAT0 + WORDS;

  logic [HDW-1:0] cmdReg;
  logic [HDW-1:0] datReg [WORDS];
  logic [HDW-1:0] weReg  [WORDS];
  logic [TDW-1:0] datFlat, weFlat, mergeReg;
  logic           doneFlag, errFlag;
  logic           stWrite;

  assign cmdWrite = hostWrEn && (hostAddr == RAW'(REG_CMD));
  assign stWrite  = hostWrEn && (hostAddr == RAW'(REG_STAT));
  assign cmdWnr   = hostWData[WNR_BIT];
  assign cmdTgt   = hostWData[TGT_BIT];

  genvar gw;
  generate
    for (gw = 0; gw < WORDS; gw++) begin : g_flat
      assign datFlat[gw*HDW +: HDW] = datReg[gw];
      assign weFlat[gw*HDW +: HDW]  = weReg[gw];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (stb.accept) begin
      cmdReg <= hostWData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) begin
        datReg[i] <= '0;
        weReg[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (hostWrEn && hostAddr == RAW'(REG_WE0 + i)) weReg[i] <= hostWData;
        if (stb.capRead && !stb.tgtBuf) begin
          datReg[i] <= tblRData[i*HDW +: HDW];
        end else if (stb.capRead && stb.tgtBuf) begin
          if (i == 0) datReg[i] <= {{(HDW-BDW){1'b0}}, bufRData};
        end else if (hostWrEn && hostAddr == RAW'(REG_DAT0 + i)) begin
          datReg[i] <= hostWData;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mergeReg <= '0;
    end else if (stb.capOld) begin
      mergeReg <= (tblRData & ~weFlat) | (datFlat & weFlat);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (stb.setDone)     doneFlag <= 1'b1;
      else if (stb.accept) doneFlag <= 1'b0;
      else if (stWrite)    doneFlag <= doneFlag & hostWData[0];
      if (stb.setErr)      errFlag  <= 1'b1;
      else if (stWrite)    errFlag  <= errFlag & hostWData[1];
    end
  end

  assign tblEn    = (stb.ramRd || stb.ramWr) && !stb.tgtBuf;
  assign tblWe    = stb.ramWr && !stb.tgtBuf;
  assign tblAddr  = cmdReg[TAW-1:0];
  assign tblWData = mergeReg;
  assign bufEn    = (stb.ramRd || stb.ramWr) && stb.tgtBuf;
  assign bufWe    = stb.ramWr && stb.tgtBuf;
  assign bufAddr  = cmdReg[BAW-1:0];
  assign bufWData = datReg[0][BDW-1:0];

  always_comb begin
    hostRData = '0;
    if (hostAddr == RAW'(REG_CMD))  hostRData = cmdReg;
    if (hostAddr == RAW'(REG_STAT)) hostRData = {{(HDW-2){1'b0}}, errFlag, doneFlag};
    for (int i = 0; i < WORDS; i++) begin
      if (hostAddr == RAW'(REG_DAT0 + i)) hostRData = datReg[i];
      if (hostAddr == RAW'(REG_WE0 + i))  hostRData = weReg[i];
    end
  end

  // R1: never both memories in one cycle
  p_ram_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tblEn, bufEn}));

  // R9: a command during a running access leaves the command register alone
  p_busy_cmd_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && busy) |=> $stable(cmdReg));

  // R9: and raises the error flag
  p_busy_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && busy) |=> errFlag);

  // R8: acceptance clears done
  p_accept_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.accept |=> !doneFlag);

  // R8: completion wins over a concurrent host clear
  p_done_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.setDone |=> doneFlag);

endmodule

// File: rtl/indirect_ram_bridge.sv
module indirect_ram_bridge
  import rambridge_pkg::*;
#(
  parameter int HDW     = 32,
  parameter int TDW     = 128,
  parameter int TAW     = 8,
  parameter int BDW     = 8,
  parameter int BAW     = 14,
  parameter int RAW     = 4,
  parameter int WNR_BIT = 31,
  parameter int TGT_BIT = 30
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           hostWrEn,
  input  logic [RAW-1:0] hostAddr,
  input  logic [HDW-1:0] hostWData,
  output logic [HDW-1:0] hostRData,
  output logic           tblEn,
  output logic           tblWe,
  output logic [TAW-1:0] tblAddr,
  output logic [TDW-1:0] tblWData,
  input  logic [TDW-1:0] tblRData,
  output logic           bufEn,
  output logic           bufWe,
  output logic [BAW-1:0] bufAddr,
  output logic [BDW-1:0] bufWData,
  input  logic [BDW-1:0] bufRData
);

  ctlStrobe_t stb;
  logic busy, cmdWrite, cmdWnr, cmdTgt;

  rambridge_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdWnr(cmdWnr),
    .cmdTgt(cmdTgt), .stb(stb), .busy(busy)
  );

  rambridge_dp #(
    .HDW(HDW), .TDW(TDW), .TAW(TAW), .BDW(BDW), .BAW(BAW), .RAW(RAW),
    .WNR_BIT(WNR_BIT), .TGT_BIT(TGT_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWData(hostWData),
    .hostRData(hostRData), .cmdWrite(cmdWrite), .cmdWnr(cmdWnr), .cmdTgt(cmdTgt),
    .tblEn(tblEn), .tblWe(tblWe), .tblAddr(tblAddr), .tblWData(tblWData),
    .tblRData(tblRData), .bufEn(bufEn), .bufWe(bufWe), .bufAddr(bufAddr),
    .bufWData(bufWData), .bufRData(bufRData)
  );

endmodule

// File: tb/tb_indirect_ram_bridge.sv
module tb_indirect_ram_bridge;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         hostWrEn = 1'b0;
  logic [3:0]   hostAddr = 4'd1;
  logic [31:0]  hostWData = '0;
  logic [31:0]  hostRData;
  logic         tblEn, tblWe, bufEn, bufWe;
  logic [7:0]   tblAddr;
  logic [127:0] tblWData, tblRData;
  logic [13:0]  bufAddr;
  logic [7:0]   bufWData, bufRData;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  indirect_ram_bridge dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWData(hostWData), .hostRData(hostRData), .tblEn(tblEn), .tblWe(tblWe),
    .tblAddr(tblAddr), .tblWData(tblWData), .tblRData(tblRData), .bufEn(bufEn),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufWData(bufWData), .bufRData(bufRData)
  );

  function automatic logic [127:0] tblInit(int i);
    logic [127:0] v;
    for (int w = 0; w < 4; w++) v[w*32 +: 32] = 32'h9E3779B9 * (i*4 + w + 1);
    return v;
  endfunction

  function automatic logic [7:0] bufInit(int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  // Behavioural RAM models
  logic [127:0] tblMem [256];
  logic [7:0]   bufMem [256];
  logic [13:0]  lastBufAddr = '0;
  int tblRdCnt = 0, tblWrCnt = 0, bufRdCnt = 0, bufWrCnt = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) begin
        tblMem[i] <= tblInit(i);
        bufMem[i] <= bufInit(i);
      end
      tblRData <= '0;
      bufRData <= '0;
    end else begin
      if (tblEn) begin
        if (tblWe) begin tblMem[tblAddr] <= tblWData; tblWrCnt <= tblWrCnt + 1; end
        else tblRdCnt <= tblRdCnt + 1;
        tblRData <= tblMem[tblAddr];
      end
      if (bufEn) begin
        lastBufAddr <= bufAddr;
        if (bufWe) begin bufMem[bufAddr[7:0]] <= bufWData; bufWrCnt <= bufWrCnt + 1; end
        else bufRdCnt <= bufRdCnt + 1;
        bufRData <= bufMem[bufAddr[7:0]];
      end
    end
  end

  logic [127:0] tblShadow [256];
  logic [7:0]   bufShadow [256];

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWrite(logic [3:0] a, logic [31:0] d);
    hostAddr  = a;
    hostWData = d;
    hostWrEn  = 1'b1;
    @(negedge clk);
    hostWrEn  = 1'b0;
    hostAddr  = 4'd1;
  endtask

  task automatic hostRead(logic [3:0] a, output logic [31:0] d);
    hostAddr = a;
    #1;
    d = hostRData;
    hostAddr = 4'd1;
  endtask

  // Issue a command; return clocks until done is seen
  task automatic runCmd(logic [31:0] cmd, output int lat);
    logic [31:0] st;
    hostWrite(4'd0, cmd);
    hostRead(4'd1, st);
    check("R8 done cleared on accept", st[0], 1'b0);
    lat = 99;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      hostRead(4'd1, st);
      if (st[0]) begin lat = k; break; end
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic [127:0] datV, weV;
    int lat, t0, t1, b0, b1;

    for (int i = 0; i < 256; i++) begin
      tblShadow[i] = tblInit(i);
      bufShadow[i] = bufInit(i);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 / R11: reset values across the whole offset range
    for (int a = 0; a < 16; a++) begin
      hostRead(4'(a), rd);
      check("R10 R11 reset register value", rd, 32'h0);
    end
    t0 = tblRdCnt + tblWrCnt + bufRdCnt + bufWrCnt;

    // R1: holding the command offset without writing starts nothing
    hostAddr = 4'd0;
    repeat (5) @(negedge clk);
    hostAddr = 4'd1;
    check("R1 R10 no RAM access when idle", tblRdCnt + tblWrCnt + bufRdCnt + bufWrCnt, t0);

    // R3: documented masked update of entry 87h word 2
    hostWrite(4'd4, 32'h7B070000);
    hostWrite(4'd8, 32'hFFFF0000);
    runCmd(32'h80000087, lat);
    check("R7 table write latency", lat, 3);
    tblShadow[8'h87][95:80] = 16'h7B07;
    check("R3 masked example entry", tblMem[8'h87], tblShadow[8'h87]);
    hostRead(4'd0, rd);
    check("R2 command readback", rd, 32'h80000087);

    // R3 / R4: sweep every table entry with varied data and masks
    for (int e = 0; e < 256; e++) begin
      for (int w = 0; w < 4; w++) begin
        datV[w*32 +: 32] = 32'hC3A50000 ^ (e << 8) ^ (w << 4) ^ e ^ (w * 32'h11110000);
        weV[w*32 +: 32]  = {8'(e), ~8'(e), 8'(e) ^ 8'h5A, 8'(w * 8'h33)};
        hostWrite(4'(2 + w), datV[w*32 +: 32]);
        hostWrite(4'(6 + w), weV[w*32 +: 32]);
      end
      t0 = tblRdCnt; t1 = tblWrCnt;
      runCmd({1'b1, 1'b0, 22'd0, 8'(e)}, lat);
      check("R7 table write latency", lat, 3);
      check("R1 one table read per write", tblRdCnt - t0, 1);
      check("R1 one table write per write", tblWrCnt - t1, 1);
      tblShadow[e] = (tblShadow[e] & ~weV) | (datV & weV);
      check("R3 masked table write", tblMem[e], tblShadow[e]);
      t0 = tblRdCnt; t1 = tblWrCnt;
      runCmd({1'b0, 1'b0, 22'd0, 8'(e)}, lat);
      check("R7 table read latency", lat, 2);
      check("R1 table read single cycle", (tblRdCnt - t0) * 16 + (tblWrCnt - t1), 16);
      for (int w = 0; w < 4; w++) begin
        hostRead(4'(2 + w), rd);
        check("R4 table read word", rd, tblShadow[e][w*32 +: 32]);
      end
    end

    // R5 / R6: buffer sweep with enables all set and junk upper data words
    for (int w = 0; w < 4; w++) hostWrite(4'(6 + w), 32'hFFFFFFFF);
    for (int a = 0; a < 256; a++) begin
      logic [13:0] ad;
      logic [7:0]  by;
      ad = 14'((a * 67 + (a << 8)) & 14'h3FFF);
      by = 8'(a ^ 8'hA7);
      hostWrite(4'd2, {24'hDEADBE, by});
      for (int w = 1; w < 4; w++) hostWrite(4'(2 + w), 32'h5A000000 + a * 4 + w);
      t0 = tblRdCnt + tblWrCnt; b0 = bufWrCnt; b1 = bufRdCnt;
      runCmd({1'b1, 1'b1, 16'd0, ad}, lat);
      check("R7 buffer write latency", lat, 1);
      check("R5 buffer write single cycle", (bufWrCnt - b0) * 16 + (bufRdCnt - b1), 16);
      check("R5 table untouched on buffer write", tblRdCnt + tblWrCnt, t0);
      check("R2 buffer address field", lastBufAddr, ad);
      bufShadow[ad[7:0]] = by;
      check("R5 buffer byte stored", bufMem[ad[7:0]], bufShadow[ad[7:0]]);
      hostWrite(4'd2, 32'hFFFFFFFF);
      runCmd({1'b0, 1'b1, 16'd0, ad}, lat);
      check("R7 buffer read latency", lat, 2);
      hostRead(4'd2, rd);
      check("R6 buffer read zero-extended", rd, {24'h0, bufShadow[ad[7:0]]});
      hostRead(4'd4, rd);
      check("R6 upper words kept", rd, 32'h5A000000 + a * 4 + 2);
    end

    // R9: a second command one clock after the first is dropped
    b0 = bufWrCnt;
    hostWrite(4'd0, 32'h00000005);
    hostWrite(4'd0, 32'hC0000033);
    repeat (4) @(negedge clk);
    hostRead(4'd1, rd);
    check("R9 error set, first command done", rd[1:0], 2'b11);
    hostRead(4'd0, rd);
    check("R9 command register keeps first", rd, 32'h00000005);
    check("R9 no buffer write from dropped command", bufWrCnt - b0, 0);
    hostRead(4'd2, rd);
    check("R9 first command read data", rd, tblShadow[5][31:0]);
    hostWrite(4'd1, 32'h00000001);
    hostRead(4'd1, rd);
    check("R9 error cleared by writing 0", rd[1:0], 2'b01);

    // R8: clear of done in the same cycle as a completion
    hostWrite(4'd0, 32'h40000010);
    @(negedge clk);
    hostWrite(4'd1, 32'h00000000);
    hostRead(4'd1, rd);
    check("R8 completion wins over clear", rd[0], 1'b1);
    hostWrite(4'd1, 32'h00000000);
    hostRead(4'd1, rd);
    check("R8 host clear of done", rd[0], 1'b0);
    hostRead(4'd2, rd);
    check("R6 read after collision", rd, {24'h0, bufShadow[8'h10]});
    hostRead(4'd10, rd);
    check("R11 unmapped offset reads zero", rd, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
    $finish;
  end

endmodule